// File: doc/BRIEF.md
# Single-Cycle Successive Cancellation Polar Decoder

This block turns a vector of N channel log-likelihood ratios into the N-bit estimate of the uncoded polar input word. The whole successive cancellation schedule sits in combinational logic between one input register stage and one output register stage. A new codeword and a new information mask can therefore enter on every clock edge, and the decoded word for it appears one edge later. Because the mask is sampled along with the LLRs, the code rate and the frozen set can change from one codeword to the next.

The datapath is built recursively. A length-N node splits its LLRs into adjacent pairs. It forms a min-sum f value for each pair and decodes those values with a half-length node. It then encodes the left-half decisions with a half-length XOR polar transform to get partial sums. With those partial sums it forms saturating g values for each pair and decodes them with a second half-length node. A fixed length-4 core ends the recursion. In that core, the first even bit is a parity of input signs and each odd bit is chosen by a single magnitude comparison, so no adder is needed for these decisions.

Top module: `polar_sc_decoder`

## Requirements
- R1: While reset is asserted the decoded output is all zeros.
- R2: An LLR vector and mask presented before clock edge k are captured at edge k, and their decoded word is visible on `u_hat` after edge k+1 and not earlier.
- R3: Mask bit i equal to 0 marks bit i frozen, and `u_hat[i]` is then 0 whatever the LLRs.
- R4: Each LLR is 5 bits in sign-magnitude form, with bit 4 the sign (1 = negative) and bits 3:0 the magnitude. A hard decision takes the sign bit as it is, so a negative zero decides 1.
- R5: f of two LLRs has the XOR of their signs as its sign and the smaller of their magnitudes as its magnitude.
- R6: g(p, q, v) equals q + p when v = 0 and q − p when v = 1. The magnitude of the result saturates at 15, and a zero result carries a positive sign.
- R7: `u_hat[0]` equals the XOR of all N input sign bits, ANDed with mask bit 0.
- R8: An unfrozen odd bit whose pair is (p, q) and whose even neighbour is e takes the sign of q when |q| ≥ |p|, and otherwise the sign of p XOR e. Ties go to q.
- R9: Pairs are adjacent LLRs (2i, 2i+1) with the lower index as p. The left half decodes the f values into `u_hat[N/2-1:0]`. The right half decodes g values that use the left decisions after a length-N/2 XOR polar transform, in which x[i] ^= x[i+h] for every stage h with bit h of i clear.
- R10: When all captured LLR signs are 0, every decoded bit is 0 for any mask.
- R11: For any input, the full output word matches a bit-exact successive cancellation model built from R4 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every rising edge captures a codeword and registers a result |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| llr_in | input | N*5 | Channel LLRs, element i at bits [5i+4:5i], sign-magnitude |
| info_in | input | N | Information mask, 1 = information bit, 0 = frozen |
| u_hat | output | N | Decoded uncoded word, bit i is index i |

## Verification
Two cases are hard to reach with uniform random LLRs: saturation of g deep in the tree, and exact magnitude ties in the odd-bit rule. Ties almost never occur, and saturation needs large values that have been added in the same direction at more than one level. The stimulus therefore includes sweeps whose magnitudes come from a tiny set ({2,3}) and sweeps limited to 12..15, so that ties and clamping happen on most codewords. The bench also sweeps all 256 masks so that every partial-sum pattern reaches the right half.

// File: rtl/polar_pkg.sv
package polar_pkg;
  localparam int LLR_W   = 5;
  localparam int MAG_W   = LLR_W - 1;
  localparam int SUM_W   = LLR_W + 1;
  localparam int MAG_MAX = (1 << MAG_W) - 1;

  typedef logic [LLR_W-1:0] llr_t;

  function automatic llr_t f_minsum(input llr_t p, input llr_t q);
    logic [MAG_W-1:0] m;
    m = (p[MAG_W-1:0] < q[MAG_W-1:0]) ? p[MAG_W-1:0] : q[MAG_W-1:0];
    return {p[MAG_W] ^ q[MAG_W], m};
  endfunction

  function automatic logic signed [SUM_W-1:0] to_signed(input llr_t p);
    logic signed [SUM_W-1:0] m;
    m = $signed({2'b00, p[MAG_W-1:0]});
    return p[MAG_W] ? -m : m;
  endfunction

  function automatic llr_t clamp_sm(input logic signed [SUM_W-1:0] x);
    logic [SUM_W-1:0] mag_full;
    logic [MAG_W-1:0] mag;
    mag_full = (x < 0) ? $unsigned(-x) : $unsigned(x);
    mag = (mag_full > SUM_W'(MAG_MAX)) ? MAG_W'(MAG_MAX) : mag_full[MAG_W-1:0];
    return {(x < 0), mag};
  endfunction

  // both candidates are formed, the partial sum only selects
  function automatic llr_t g_select(input llr_t p, input llr_t q, input logic v);
    logic signed [SUM_W-1:0] sp, sq;
    llr_t plus_r, minus_r;
    sp = to_signed(p);
    sq = to_signed(q);
    plus_r  = clamp_sm(sq + sp);
    minus_r = clamp_sm(sq - sp);
    return v ? minus_r : plus_r;
  endfunction

  function automatic logic odd_decide(input llr_t p, input llr_t q,
                                      input logic even_bit, input logic info);
    logic d;
    d = (q[MAG_W-1:0] >= p[MAG_W-1:0]) ? q[MAG_W] : (p[MAG_W] ^ even_bit);
    return d & info;
  endfunction
endpackage

// File: rtl/polar_fg_stage.sv
module polar_fg_stage #(
  parameter int M = 2
) (
  input  polar_pkg::llr_t [2*M-1:0] llr_in,
  input  logic [M-1:0]              psum,
  output polar_pkg::llr_t [M-1:0]   f_out,
  output polar_pkg::llr_t [M-1:0]   g_out
);
  for (genvar i = 0; i < M; i++) begin : g_pair
    assign f_out[i] = polar_pkg::f_minsum(llr_in[2*i], llr_in[2*i+1]);
    assign g_out[i] = polar_pkg::g_select(llr_in[2*i], llr_in[2*i+1], psum[i]);
  end
endmodule

// File: rtl/polar_xor_enc.sv
module polar_xor_enc #(
  parameter int M = 4
) (
  input  logic [M-1:0] u_in,
  output logic [M-1:0] x_out
);
  localparam int STAGES = (M > 1) ? $clog2(M) : 0;

  always_comb begin
    x_out = u_in;
    for (int s = 0; s < STAGES; s++) begin
      for (int i = 0; i < M; i++) begin
        if (((i >> s) & 1) == 0) begin
          x_out[i] = x_out[i] ^ x_out[i + (1 << s)];
        end
      end
    end
  end
endmodule

// File: rtl/polar_core4.sv
module polar_core4 (
  input  polar_pkg::llr_t [3:0] llr_in,
  input  logic [3:0]            info,
  output logic [3:0]            u_hat
);
  import polar_pkg::*;
  localparam int SB = LLR_W - 1;

  llr_t alpha0, alpha1, beta0, beta1;

  always_comb begin
    alpha0   = f_minsum(llr_in[0], llr_in[1]);
    alpha1   = f_minsum(llr_in[2], llr_in[3]);
    u_hat[0] = (llr_in[0][SB] ^ llr_in[1][SB] ^ llr_in[2][SB] ^ llr_in[3][SB]) & info[0];
    u_hat[1] = odd_decide(alpha0, alpha1, u_hat[0], info[1]);
    beta0    = g_select(llr_in[0], llr_in[1], u_hat[0] ^ u_hat[1]);
    beta1    = g_select(llr_in[2], llr_in[3], u_hat[1]);
    u_hat[2] = (beta0[SB] ^ beta1[SB]) & info[2];
    u_hat[3] = odd_decide(beta0, beta1, u_hat[2], info[3]);
  end
endmodule

// File: rtl/polar_sc_node.sv
module polar_sc_node #(
  parameter int N = 8
) (
  input  polar_pkg::llr_t [N-1:0] llr_in,
  input  logic [N-1:0]            info,
  output logic [N-1:0]            u_hat
);
  localparam int HALF = N / 2;

  if (N == 4) begin : g_leaf
    polar_core4 i_core (
      .llr_in (llr_in),
      .info   (info),
      .u_hat  (u_hat)
    );
  end else begin : g_split
    polar_pkg::llr_t [HALF-1:0] f_vals, g_vals;
    logic [HALF-1:0] u_lo, u_hi, psum;

    polar_fg_stage #(.M(HALF)) i_fg (
      .llr_in (llr_in),
      .psum   (psum),
      .f_out  (f_vals),
      .g_out  (g_vals)
    );

    polar_sc_node #(.N(HALF)) i_lo (
      .llr_in (f_vals),
      .info   (info[HALF-1:0]),
      .u_hat  (u_lo)
    );

    polar_xor_enc #(.M(HALF)) i_enc (
      .u_in  (u_lo),
      .x_out (psum)
    );

    polar_sc_node #(.N(HALF)) i_hi (
      .llr_in (g_vals),
      .info   (info[N-1:HALF]),
      .u_hat  (u_hi)
    );

    assign u_hat = {u_hi, u_lo};
  end
endmodule

// File: rtl/polar_sc_decoder.sv
module polar_sc_decoder #(
  parameter int N = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N-1:0][polar_pkg::LLR_W-1:0]   llr_in,
  input  logic [N-1:0]                         info_in,
  output logic [N-1:0]                         u_hat
);
  logic rst_meta, rst_sync;
  polar_pkg::llr_t [N-1:0] llr_q;
  logic [N-1:0] info_q, dec_u, u_q;
  logic [N-1:0] u_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  polar_sc_node #(.N(N)) i_root (
    .llr_in (llr_q),
    .info   (info_q),
    .u_hat  (dec_u)
  );

  always_comb begin
    u_d = dec_u;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      llr_q  <= '0;
      info_q <= '0;
      u_q    <= '0;
    end else begin
      llr_q  <= llr_in;
      info_q <= info_in;
      u_q    <= u_d;
    end
  end

  assign u_hat = u_q;
endmodule

// File: rtl/polar_sc_checker.sv
module polar_sc_checker #(
  parameter int N = 8
) (
  input logic                          clk,
  input logic                          rst_sync,
  input polar_pkg::llr_t [N-1:0]       llr_q,
  input logic [N-1:0]                  info_q,
  input logic [N-1:0]                  u_hat
);
  logic [N-1:0] signs;
  always_comb begin
    for (int i = 0; i < N; i++) signs[i] = llr_q[i][polar_pkg::LLR_W-1];
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_sync |-> (u_hat == '0));

  a_r3_frozen_zero: assert property (@(posedge clk) disable iff (!rst_sync)
    (info_q != '1) |=> ((u_hat & ~$past(info_q)) == '0));

  a_r7_first_parity: assert property (@(posedge clk) disable iff (!rst_sync)
    info_q[0] |=> (u_hat[0] == $past(^signs)));

  a_r10_all_positive: assert property (@(posedge clk) disable iff (!rst_sync)
    (signs == '0) |=> (u_hat == '0));
endmodule

bind polar_sc_decoder polar_sc_checker #(.N(N)) i_chk (
  .clk      (clk),
  .rst_sync (rst_sync),
  .llr_q    (llr_q),
  .info_q   (info_q),
  .u_hat    (u_hat)
);

// File: tb/test_polar_sc_decoder.sv
module test_polar_sc_decoder;
  localparam int N = 8;

  logic clk, rst_n;
  logic [N-1:0][4:0] llr;
  logic [N-1:0] info;
  logic [N-1:0] uh;
  int checks = 0;
  int errors = 0;

  polar_sc_decoder #(.N(N)) i_polar_sc_decoder (
    .clk     (clk),
    .rst_n   (rst_n),
    .llr_in  (llr),
    .info_in (info),
    .u_hat   (uh)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- bench model (R4..R9) ----------------
  function automatic logic [4:0] mf(logic [4:0] p, logic [4:0] q);
    return {p[4] ^ q[4], (p[3:0] < q[3:0]) ? p[3:0] : q[3:0]};
  endfunction

  function automatic logic [4:0] mg(logic [4:0] p, logic [4:0] q, logic v);
    int a, b, r;
    a = p[4] ? -int'(p[3:0]) : int'(p[3:0]);
    b = q[4] ? -int'(q[3:0]) : int'(q[3:0]);
    r = v ? b - a : b + a;
    if (r > 15) r = 15;
    if (r < -15) r = -15;
    if (r < 0) return {1'b1, 4'(-r)};
    return {1'b0, 4'(r)};
  endfunction

  function automatic logic [1:0] md2(logic [4:0] p, logic [4:0] q, logic [1:0] a);
    logic [1:0] u;
    u[0] = (p[4] ^ q[4]) & a[0];
    u[1] = a[1] & ((q[3:0] >= p[3:0]) ? q[4] : (p[4] ^ u[0]));
    return u;
  endfunction

  function automatic logic [3:0] md4(logic [3:0][4:0] l, logic [3:0] a);
    logic [1:0] lo, hi, v;
    lo = md2(mf(l[0], l[1]), mf(l[2], l[3]), a[1:0]);
    v  = {lo[1], lo[0] ^ lo[1]};
    hi = md2(mg(l[0], l[1], v[0]), mg(l[2], l[3], v[1]), a[3:2]);
    return {hi, lo};
  endfunction

  function automatic logic [7:0] md8(logic [7:0][4:0] l, logic [7:0] a);
    logic [3:0][4:0] lf, lg;
    logic [3:0] lo, hi, v;
    for (int i = 0; i < 4; i++) lf[i] = mf(l[2*i], l[2*i+1]);
    lo = md4(lf, a[3:0]);
    v = lo;
    for (int h = 1; h < 4; h = h * 2)
      for (int i = 0; i < 4; i++)
        if ((i & h) == 0) v[i] = v[i] ^ v[i+h];
    for (int i = 0; i < 4; i++) lg[i] = mg(l[2*i], l[2*i+1], v[i]);
    hi = md4(lg, a[7:4]);
    return {hi, lo};
  endfunction

  function automatic logic [N-1:0][4:0] gen(int lo, int hi, bit pos_only);
    logic [N-1:0][4:0] l;
    for (int i = 0; i < N; i++) begin
      l[i][3:0] = 4'(lo + int'($urandom % (hi - lo + 1)));
      l[i][4]   = pos_only ? 1'b0 : 1'($urandom);
    end
    return l;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(logic [N-1:0][4:0] l, logic [N-1:0] a);
    @(negedge clk);
    llr = l;
    info = a;
    @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic run_model(string req, logic [N-1:0][4:0] l, logic [N-1:0] a);
    apply(l, a);
    check(req, uh, md8(l, a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0][4:0] l, l2;
    logic [N-1:0] a;
    rst_n = 1'b0;
    llr = '0;
    info = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: output cleared under reset
    check("R1", uh, '0);
    llr = {N{5'b10111}};
    info = '1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", uh, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: one register stage in, one out
    l = gen(0, 15, 0);
    a = '1;
    apply(l, a);
    check("R2", uh, md8(l, a));
    l2 = gen(0, 15, 0);
    while (md8(l2, a) == md8(l, a)) l2 = gen(0, 15, 0);
    @(negedge clk);
    llr = l2;
    @(posedge clk);
    #1;
    check("R2", uh, md8(l, a));
    @(posedge clk);
    #1;
    check("R2", uh, md8(l2, a));

    // R4: negative zero decides 1 (only bit 0 unfrozen, other signs positive)
    l = {N{5'b00101}};
    l[0] = 5'b10000;
    apply(l, 8'b0000_0001);
    check("R4", uh, 8'b0000_0001);
    run_model("R4", {N{5'b10000}}, '1);

    // R3: frozen positions always zero, random masks
    for (int k = 0; k < 200; k++) begin
      l = gen(0, 15, 0);
      a = 8'($urandom);
      apply(l, a);
      check("R3", uh & ~a, '0);
    end

    // R7: bit 0 is the parity of all signs
    for (int k = 0; k < 100; k++) begin
      l = gen(0, 15, 0);
      apply(l, '1);
      a = '0;
      for (int i = 0; i < N; i++) a[0] = a[0] ^ l[i][4];
      check("R7", {7'b0, uh[0]}, {7'b0, a[0]});
    end

    // R10: all-positive LLRs decode to zero
    for (int k = 0; k < 100; k++) begin
      apply(gen(0, 15, 1), 8'($urandom));
      check("R10", uh, '0);
    end

    // R5: small distinct magnitudes exercise min selection
    for (int k = 0; k < 300; k++) run_model("R5", gen(0, 3, 0), 8'($urandom));
    // R6: large magnitudes drive g into saturation
    for (int k = 0; k < 300; k++) run_model("R6", gen(12, 15, 0), 8'($urandom));
    // R8: magnitudes {2,3} make ties frequent
    for (int k = 0; k < 400; k++) run_model("R8", gen(2, 3, 0), 8'($urandom));
    // R9: every mask, so every partial-sum pattern reaches the upper half
    for (int m = 0; m < 256; m++) run_model("R9", gen(0, 15, 0), 8'(m));
    // R11: fully random
    for (int k = 0; k < 2000; k++) run_model("R11", gen(0, 15, 0), 8'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule